// File: doc/BRIEF.md
# Unsigned Array Multiplier with Streaming Result Slot

This block multiplies two unsigned operands of `WIDTH` bits and returns a product of `2*WIDTH` bits. The arithmetic is a regular grid of cells. Each cell ANDs one bit of operand A with one bit of operand B and passes the result through a full adder. Each grid row is a ripple adder of `WIDTH` cells. It adds one shifted partial product (A ANDed with one bit of B) to the running sum from the row above. The top row starts from a zero sum. Each row contributes its least significant sum bit as one low product bit. The last row's remaining sum bits and its carry-out form the upper half of the product. There is no carry-save reduction, no recoding and no signed handling.

Operands enter on a valid/ready stream and the product leaves on a valid/ready stream. Between the two sits a single result register. A beat is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its product appears on the output one edge later. The result register may hold one product at a time. Back-pressure works as follows. While a product is waiting and `out_ready` is low, `in_ready` is low and the held product does not move. When the waiting product is taken on the same edge as a new beat arrives, the new product replaces it with no idle cycle. `WIDTH` must be at least 1.

Top module: `array_multiplier`

## Requirements
- R1: For every accepted operand pair, the product presented one edge later equals A times B as an unsigned value of 2*WIDTH bits (bit 0 is the least significant).
- R2: While `rst` is high, and on the first cycle after it falls, `out_valid` is 0 and `in_ready` is 1. A product held when reset rises is discarded.
- R3: `in_ready` is high exactly when the result register is empty or `out_ready` is high.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_prod` keeps its value, whatever the operand inputs do.
- R5: A beat accepted on an edge makes `out_valid` high after that edge.
- R6: When a product is taken and a new beat is accepted on the same edge, the next product follows with no cycle of `out_valid` low.
- R7: When a product is taken and no beat is accepted, `out_valid` falls after that edge.
- R8: A zero operand gives a zero product. Two all-ones operands give 2^(2*WIDTH) - 2^(WIDTH+1) + 1, which is 225 for WIDTH 4.
- R9: Operands 13 and 11 give 143 for WIDTH 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand beat is offered |
| in_ready | output | 1 | Block can take an operand beat this cycle |
| in_a | input | WIDTH | Multiplicand, unsigned |
| in_b | input | WIDTH | Multiplier, unsigned |
| out_valid | output | 1 | Product is held and offered |
| out_ready | input | 1 | Consumer takes the product this cycle |
| out_prod | output | 2*WIDTH | Unsigned product |

## Verification
Taking a waiting product and accepting a new operand pair can happen on the same edge. The exhaustive pass over all 256 operand pairs for WIDTH 4 keeps both `in_valid` and `out_ready` high on every cycle, so every edge does both. Each product must then appear in the very next cycle with `out_valid` still high. A directed sequence first stalls the output with a product held. It then raises `out_ready` while a different pair is offered. It checks that `in_ready` rises in the same cycle and that the new product replaces the old one after a single edge.

// File: rtl/amul_pkg.sv
package amul_pkg;

  // Result of one full-adder stage
  typedef struct packed {
    logic carry;
    logic sum;
  } fa_res_t;

  function automatic fa_res_t full_add(input logic x, input logic y, input logic z);
    fa_res_t r;
    r.sum   = x ^ y ^ z;
    r.carry = (x & y) | (x & z) | (y & z);
    return r;
  endfunction

endpackage

// File: rtl/amul_cell.sv
module amul_cell
  import amul_pkg::*;
(
  input  logic a_bit,
  input  logic b_bit,
  input  logic sum_in,
  input  logic carry_in,
  output logic sum_out,
  output logic carry_out
);

  logic    pp_bit;
  fa_res_t fa;

  assign pp_bit    = a_bit & b_bit;
  assign fa        = full_add(pp_bit, sum_in, carry_in);
  assign sum_out   = fa.sum;
  assign carry_out = fa.carry;

endmodule

// File: rtl/amul_row.sv
module amul_row #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic             b_bit,
  input  logic [WIDTH-1:0] sum_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);

  // ripple chain: chain[0] is the row carry-in (zero), chain[WIDTH] leaves
  logic [WIDTH:0] chain;

  assign chain[0] = 1'b0;

  for (genvar j = 0; j < WIDTH; j++) begin : g_cell
    amul_cell u_cell (
      .a_bit    (a[j]),
      .b_bit    (b_bit),
      .sum_in   (sum_in[j]),
      .carry_in (chain[j]),
      .sum_out  (sum_out[j]),
      .carry_out(chain[j+1])
    );
  end

  assign carry_out = chain[WIDTH];

endmodule

// File: rtl/amul_grid.sv
module amul_grid #(
  parameter int WIDTH = 4,
  localparam int PW = 2 * WIDTH
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [PW-1:0]    prod
);

  logic [WIDTH-1:0] row_in  [WIDTH];
  logic [WIDTH-1:0] row_sum [WIDTH];
  logic             row_cy  [WIDTH];

  for (genvar r = 0; r < WIDTH; r++) begin : g_row
    if (r == 0) begin : g_top
      assign row_in[0] = '0;
    end else begin : g_link
      // previous row shifted down one place, its carry entering at the top
      for (genvar j = 0; j < WIDTH; j++) begin : g_wire
        if (j == WIDTH - 1) begin : g_msb
          assign row_in[r][j] = row_cy[r-1];
        end else begin : g_mid
          assign row_in[r][j] = row_sum[r-1][j+1];
        end
      end
    end

    amul_row #(.WIDTH(WIDTH)) u_row (
      .a        (a),
      .b_bit    (b[r]),
      .sum_in   (row_in[r]),
      .sum_out  (row_sum[r]),
      .carry_out(row_cy[r])
    );

    // each row settles one low product bit
    assign prod[r] = row_sum[r][0];
  end

  // upper half from the last row
  for (genvar j = 1; j < WIDTH; j++) begin : g_hi
    assign prod[WIDTH-1+j] = row_sum[WIDTH-1][j];
  end
  assign prod[PW-1] = row_cy[WIDTH-1];

endmodule

// File: rtl/amul_slot.sv
module amul_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);

  logic          full_q;
  logic [DW-1:0] data_q;
  logic          take;

  assign in_ready  = !full_q || out_ready;
  assign take      = in_valid && in_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
    end else if (take) begin
      full_q <= 1'b1;
    end else if (out_ready) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      data_q <= in_data;
    end
  end

endmodule

// File: rtl/array_multiplier.sv
module array_multiplier #(
  parameter int WIDTH = 4,
  localparam int PW = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PW-1:0]    out_prod
);

  logic [PW-1:0] grid_prod;

  amul_grid #(.WIDTH(WIDTH)) u_grid (
    .a   (in_a),
    .b   (in_b),
    .prod(grid_prod)
  );

  amul_slot #(.DW(PW)) u_slot (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (grid_prod),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_prod)
  );

endmodule

// File: rtl/array_multiplier_chk.sv
module array_multiplier_chk #(
  parameter int WIDTH = 4,
  localparam int PW = 2 * WIDTH
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] in_a,
  input logic [WIDTH-1:0] in_b,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PW-1:0]    out_prod
);

  // R1: accepted pair yields its exact product one edge later
  assert_product_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=>
      (out_prod == PW'($past(in_a)) * PW'($past(in_b))));

  // R2: empty after reset
  assert_reset_empty_R2: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R3: a ready consumer always lets input through
  assert_ready_pass_R3: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> in_ready);

  // R4: stalled product holds
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_prod)));

  // R5: acceptance produces a valid result
  assert_accept_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R7: drain without a new beat empties the slot
  assert_drain_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

endmodule

bind array_multiplier array_multiplier_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_a     (in_a),
  .in_b     (in_b),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_prod (out_prod)
);

// File: tb/array_multiplier_test.sv
module array_multiplier_test;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 4;
  localparam int PW = 2 * W;
  localparam int NVEC = 8;

  // {a, b, expected product}
  localparam logic [15:0] VEC [NVEC] = '{
    {4'd13, 4'd11, 8'd143},
    {4'd0,  4'd9,  8'd0},
    {4'd7,  4'd0,  8'd0},
    {4'd15, 4'd15, 8'd225},
    {4'd1,  4'd15, 8'd15},
    {4'd8,  4'd8,  8'd64},
    {4'd10, 4'd5,  8'd50},
    {4'd15, 4'd1,  8'd15}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_a = '0;
  logic [W-1:0]  in_b = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [PW-1:0] out_prod;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  array_multiplier #(.WIDTH(W)) uut (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_a     (in_a),
    .in_b     (in_b),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_prod (out_prod)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
      finish_run();
    end
  end

  initial begin
    // R2: reset state
    repeat (2) @(negedge clk);
    check("R2 out_valid in reset", int'(out_valid), 0);
    check("R2 in_ready in reset", int'(in_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    check("R2 out_valid after reset", int'(out_valid), 0);

    // vector table, streamed back to back (R1 R8 R9 R6)
    out_ready = 1'b1;
    for (int k = 0; k < NVEC; k++) begin
      in_valid = 1'b1;
      in_a = VEC[k][15:12];
      in_b = VEC[k][11:8];
      @(negedge clk);
      check("R1 R8 R9 table product", int'(out_prod), int'(VEC[k][7:0]));
      check("R6 table valid", int'(out_valid), 1);
    end

    // exhaustive, accept and drain on every edge (R1 R6)
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        in_a = W'(a);
        in_b = W'(b);
        @(negedge clk);
        check("R1 exhaustive product", int'(out_prod), a * b);
        check("R6 no bubble", int'(out_valid), 1);
      end
    end

    // R7: drain with no new beat
    in_valid = 1'b0;
    @(negedge clk);
    check("R7 valid falls", int'(out_valid), 0);
    check("R3 ready when empty", int'(in_ready), 1);

    // R9 R5: load 13*11 with output stalled
    in_valid = 1'b1; in_a = 4'd13; in_b = 4'd11; out_ready = 1'b0;
    @(negedge clk);
    check("R5 valid after accept", int'(out_valid), 1);
    check("R9 13x11", int'(out_prod), 143);
    check("R3 ready low when stalled", int'(in_ready), 0);

    // R4: change operands while stalled
    in_a = 4'd2; in_b = 4'd3;
    @(negedge clk);
    check("R4 held product", int'(out_prod), 143);
    check("R4 held valid", int'(out_valid), 1);

    // R3 R6: release stall while a new pair is offered
    out_ready = 1'b1;
    #1;
    check("R3 ready follows consumer", int'(in_ready), 1);
    @(negedge clk);
    check("R6 replaced product", int'(out_prod), 6);
    check("R6 valid kept", int'(out_valid), 1);
    in_valid = 1'b0;
    @(negedge clk);
    check("R7 valid falls again", int'(out_valid), 0);

    // R2: reset discards a held product
    in_valid = 1'b1; in_a = 4'd5; in_b = 4'd5; out_ready = 1'b0;
    @(negedge clk);
    check("R5 valid before reset", int'(out_valid), 1);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R2 reset clears held", int'(out_valid), 0);
    check("R2 ready in reset", int'(in_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    check("R2 empty after reset", int'(out_valid), 0);

    finish_run();
  end

endmodule